// File: doc/BRIEF.md
# Waveform Block Generator

This block turns a small waveform memory into a framed stream of data blocks. Each block carries a programmable number of samples. The samples are read from the memory between a start address and an end address, and the read wraps back to the start when it passes the end. Consecutive blocks are separated by a programmable number of idle cycles. Every block is stamped with a 64-bit block sequence number, and a sync marker appears on the first beat of every N-th block.

A host sets the timing through a small write-only register port and loads the waveform through a separate memory write port. Generation starts at once when the immediate-enable bit is set. When the arm bit is set instead, generation starts on the next rising edge of a once-per-second pulse input. Clearing both bits stops the stream at a packet boundary, so a block is never cut short.

Top module: `wave_block_gen`

## Requirements
- R1: After reset, out_valid, out_sop, out_eop and out_sync are low. The configuration defaults are 256 samples per block, 80 gap cycles, 781250 blocks per sync, start address 0, end address equal to the last memory word, initial sequence number 0, and control 0.
- R2: Register offsets on reg_addr are: 0 control, 1 samples per block, 2 blocks per sync, 3 gap cycles, 4 start address, 5 end address, 6 sequence-number low word, 7 sequence-number high word. Writing control bit 0 = 1 starts generation with no further condition. out_sop of the first block is high after the second rising edge that follows the edge which captured the write.
- R3: With control = 2'b10, nothing is emitted until pps is seen rising. out_sop of the first block is then high after the second rising edge counted from the edge that sampled pps high.
- R4: Each block is a run of contiguous valid beats, as many as the samples-per-block value. out_sop marks the first beat and out_eop the last. out_sop, out_eop and out_sync are never high without out_valid. A samples-per-block value of 0 acts as 1.
- R5: The samples of each block are read starting at the start address. The address then rises by one per beat and returns to the start address after the end address has been used (start ≤ end).
- R6: Between the out_eop of one block and the out_sop of the next block in the same run there are exactly "gap" cycles with out_valid low. A gap of 0 gives back-to-back blocks.
- R7: The first block of a run carries out_bsn = {word at offset 7, word at offset 6}. Each later block carries the previous value plus one, modulo 2^64. out_bsn is constant over all beats of a block.
- R8: Blocks in a run are numbered k = 0, 1, 2, and so on. out_sync is high on the out_sop beat of block k exactly when k mod blocks-per-sync = 0. A blocks-per-sync value of 0 acts as 1.
- R9: When control returns to 0, the block in flight is completed and then the stream stops. If the generator is in a gap at that time, it stops at once with no further beat.
- R10: A word written through the memory write port is used by every block read after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wr_data | input | 32 | Register write data |
| mem_wr_en | input | 1 | Waveform memory write strobe |
| mem_wr_addr | input | ADDR_W | Waveform memory write address |
| mem_wr_data | input | DATA_W | Waveform memory write data |
| pps | input | 1 | Once-per-second pulse used by armed start |
| out_valid | output | 1 | Sample beat valid |
| out_sop | output | 1 | First beat of a block |
| out_eop | output | 1 | Last beat of a block |
| out_sync | output | 1 | Sync marker on the first beat of a sync block |
| out_bsn | output | 64 | Block sequence number |
| out_data | output | DATA_W | Waveform sample |

## Verification
A register write reaches the control register on its capture edge. The sequencer enters its data state one edge later, and the memory read and the output flags appear after one more edge. The bench therefore samples out_sop at the falling edge after the second following rising edge, and for pps it counts from the edge that sampled the pulse. Beat contents, sequence numbers and sync flags are not tied to fixed cycles. A driver queues every expected beat before the run starts, and a monitor pops one entry on each falling edge where out_valid is high. The monitor also counts the idle cycles before each out_sop and compares them with the gap setting. Stop requests are timed from the observed out_sop of the final block. After each stop the bench waits long enough to see that the queue has drained and that no extra beat has appeared.

// File: rtl/wbg_pkg.sv
`timescale 1ns/1ps
package wbg_pkg;
    localparam int REG_W = 32;
    localparam int BSN_W = 2 * REG_W;
    localparam int OFS_W = 3;

    // Register offsets seen by the host
    localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_SPP    = 3'd1;
    localparam logic [OFS_W-1:0] OFS_BPS    = 3'd2;
    localparam logic [OFS_W-1:0] OFS_GAP    = 3'd3;
    localparam logic [OFS_W-1:0] OFS_LO     = 3'd4;
    localparam logic [OFS_W-1:0] OFS_HI     = 3'd5;
    localparam logic [OFS_W-1:0] OFS_BSN_LO = 3'd6;
    localparam logic [OFS_W-1:0] OFS_BSN_HI = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_GAP  = 2'd2
    } wbg_state_e;
endpackage

// File: rtl/wbg_cfg_regs.sv
`timescale 1ns/1ps
module wbg_cfg_regs
    import wbg_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int SPP_W   = 16,
    parameter int BPS_W   = 20,
    parameter int GAP_W   = 16,
    parameter int SPP_RST = 256,
    parameter int BPS_RST = 781250,
    parameter int GAP_RST = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [1:0]        ctrl,
    output logic [SPP_W-1:0]  spp,
    output logic [BPS_W-1:0]  bps,
    output logic [GAP_W-1:0]  gap,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi,
    output logic [BSN_W-1:0]  bsn_init
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [1:0]        ctrl;
        logic [SPP_W-1:0]  spp;
        logic [BPS_W-1:0]  bps;
        logic [GAP_W-1:0]  gap;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [BSN_W-1:0]  bsn;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                OFS_CTRL:   cfg_d.ctrl = wr_data[1:0];
                OFS_SPP:    cfg_d.spp  = wr_data[SPP_W-1:0];
                OFS_BPS:    cfg_d.bps  = wr_data[BPS_W-1:0];
                OFS_GAP:    cfg_d.gap  = wr_data[GAP_W-1:0];
                OFS_LO:     cfg_d.lo   = wr_data[ADDR_W-1:0];
                OFS_HI:     cfg_d.hi   = wr_data[ADDR_W-1:0];
                OFS_BSN_LO: cfg_d.bsn[REG_W-1:0]       = wr_data;
                OFS_BSN_HI: cfg_d.bsn[BSN_W-1:REG_W]   = wr_data;
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.ctrl <= '0;
            cfg_q.spp  <= SPP_W'(SPP_RST);
            cfg_q.bps  <= BPS_W'(BPS_RST);
            cfg_q.gap  <= GAP_W'(GAP_RST);
            cfg_q.lo   <= '0;
            cfg_q.hi   <= ADDR_W'(DEPTH - 1);
            cfg_q.bsn  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ctrl     = cfg_q.ctrl;
    assign spp      = cfg_q.spp;
    assign bps      = cfg_q.bps;
    assign gap      = cfg_q.gap;
    assign lo       = cfg_q.lo;
    assign hi       = cfg_q.hi;
    assign bsn_init = cfg_q.bsn;
endmodule

// File: rtl/wbg_wave_ram.sv
`timescale 1ns/1ps
module wbg_wave_ram #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // One-cycle registered read; the sequencer delays its flags to match
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        rd_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/wbg_sequencer.sv
`timescale 1ns/1ps
module wbg_sequencer
    import wbg_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int SPP_W  = 16,
    parameter int BPS_W  = 20,
    parameter int GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ctrl,
    input  logic [SPP_W-1:0]  spp,
    input  logic [BPS_W-1:0]  bps,
    input  logic [GAP_W-1:0]  gap,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic [BSN_W-1:0]  bsn_init,
    input  logic              pps,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              o_valid,
    output logic              o_sop,
    output logic              o_eop,
    output logic              o_sync,
    output logic [BSN_W-1:0]  o_bsn
);
    typedef struct packed {
        wbg_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [SPP_W-1:0]  samp;
        logic [GAP_W-1:0]  gcnt;
        logic [BPS_W-1:0]  blk;
        logic [BSN_W-1:0]  bsn;
        logic              pps_prev;
        // output stage, aligned with the memory read register
        logic              v;
        logic              sop;
        logic              eop;
        logic              sync;
        logic [BSN_W-1:0]  obsn;
    } seq_t;

    seq_t seq_d, seq_q;

    logic pps_rise;
    logic keep_on;
    logic go;
    logic samp_last;
    logic blk_last;
    logic gap_done;

    always_comb begin
        pps_rise  = pps & ~seq_q.pps_prev;
        keep_on   = |ctrl;
        go        = ctrl[0] | (ctrl[1] & pps_rise);
        samp_last = ({1'b0, seq_q.samp} + (SPP_W+1)'(1)) >= {1'b0, spp};
        blk_last  = ({1'b0, seq_q.blk}  + (BPS_W+1)'(1)) >= {1'b0, bps};
        gap_done  = ({1'b0, seq_q.gcnt} + (GAP_W+1)'(1)) >= {1'b0, gap};

        seq_d          = seq_q;
        seq_d.pps_prev = pps;
        seq_d.v        = 1'b0;
        seq_d.sop      = 1'b0;
        seq_d.eop      = 1'b0;
        seq_d.sync     = 1'b0;

        case (seq_q.st)
            ST_IDLE: begin
                if (go) begin
                    seq_d.st   = ST_DATA;
                    seq_d.addr = lo;
                    seq_d.samp = '0;
                    seq_d.blk  = '0;
                    seq_d.bsn  = bsn_init;
                end
            end
            ST_DATA: begin
                seq_d.v    = 1'b1;
                seq_d.sop  = (seq_q.samp == '0);
                seq_d.eop  = samp_last;
                seq_d.sync = (seq_q.samp == '0) && (seq_q.blk == '0);
                seq_d.obsn = seq_q.bsn;
                if (samp_last) begin
                    seq_d.samp = '0;
                    seq_d.addr = lo;
                    seq_d.gcnt = '0;
                    seq_d.bsn  = seq_q.bsn + BSN_W'(1);
                    seq_d.blk  = blk_last ? '0 : seq_q.blk + BPS_W'(1);
                    if (!keep_on) begin
                        seq_d.st = ST_IDLE;
                    end else if (gap == '0) begin
                        seq_d.st = ST_DATA;
                    end else begin
                        seq_d.st = ST_GAP;
                    end
                end else begin
                    seq_d.samp = seq_q.samp + SPP_W'(1);
                    seq_d.addr = (seq_q.addr == hi) ? lo : seq_q.addr + ADDR_W'(1);
                end
            end
            ST_GAP: begin
                if (!keep_on) begin
                    seq_d.st = ST_IDLE;
                end else if (gap_done) begin
                    seq_d.st = ST_DATA;
                end else begin
                    seq_d.gcnt = seq_q.gcnt + GAP_W'(1);
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_addr = seq_q.addr;
    assign o_valid = seq_q.v;
    assign o_sop   = seq_q.sop;
    assign o_eop   = seq_q.eop;
    assign o_sync  = seq_q.sync;
    assign o_bsn   = seq_q.obsn;
endmodule

// File: rtl/wave_block_gen.sv
`timescale 1ns/1ps
module wave_block_gen
    import wbg_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int SPP_W  = 16,
    parameter int BPS_W  = 20,
    parameter int GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] mem_wr_addr,
    input  logic [DATA_W-1:0] mem_wr_data,
    input  logic              pps,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_sync,
    output logic [BSN_W-1:0]  out_bsn,
    output logic [DATA_W-1:0] out_data
);
    logic [1:0]        cfg_ctrl;
    logic [SPP_W-1:0]  cfg_spp;
    logic [BPS_W-1:0]  cfg_bps;
    logic [GAP_W-1:0]  cfg_gap;
    logic [ADDR_W-1:0] cfg_lo;
    logic [ADDR_W-1:0] cfg_hi;
    logic [BSN_W-1:0]  cfg_bsn;
    logic [ADDR_W-1:0] rd_addr;

    wbg_cfg_regs #(
        .ADDR_W(ADDR_W), .SPP_W(SPP_W), .BPS_W(BPS_W), .GAP_W(GAP_W)
    ) i_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wr_data),
        .ctrl(cfg_ctrl), .spp(cfg_spp), .bps(cfg_bps), .gap(cfg_gap),
        .lo(cfg_lo), .hi(cfg_hi), .bsn_init(cfg_bsn)
    );

    wbg_wave_ram #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) i_ram (
        .clk(clk),
        .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
        .rd_addr(rd_addr), .rd_data(out_data)
    );

    wbg_sequencer #(
        .ADDR_W(ADDR_W), .SPP_W(SPP_W), .BPS_W(BPS_W), .GAP_W(GAP_W)
    ) i_seq (
        .clk(clk), .rst(rst),
        .ctrl(cfg_ctrl), .spp(cfg_spp), .bps(cfg_bps), .gap(cfg_gap),
        .lo(cfg_lo), .hi(cfg_hi), .bsn_init(cfg_bsn), .pps(pps),
        .rd_addr(rd_addr),
        .o_valid(out_valid), .o_sop(out_sop), .o_eop(out_eop),
        .o_sync(out_sync), .o_bsn(out_bsn)
    );
endmodule

// File: rtl/wbg_checker.sv
`timescale 1ns/1ps
module wbg_checker #(
    parameter int GAP_W = 16,
    parameter int BSN_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_sync,
    input logic [BSN_W-1:0] out_bsn,
    input logic [GAP_W-1:0] gap_cfg
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid); // R1

    AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
        (out_sop || out_eop || out_sync) |-> out_valid); // R4

    AST_PKT_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sop) |-> ($past(out_valid) && !$past(out_eop))); // R4

    AST_GAP_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(out_eop) && gap_cfg != '0) |-> !out_valid); // R6

    AST_SOP_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
        (out_sop && $past(out_valid)) |-> $past(out_eop)); // R6

    AST_BSN_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sop) |-> (out_bsn == $past(out_bsn))); // R7

    AST_SYNC_ON_SOP: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> out_sop); // R8
endmodule

bind wave_block_gen wbg_checker #(.GAP_W(GAP_W), .BSN_W(wbg_pkg::BSN_W)) i_chk (
    .clk(clk), .rst(rst),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_sync(out_sync), .out_bsn(out_bsn), .gap_cfg(cfg_gap)
);

// File: tb/test_wave_block_gen.sv
`timescale 1ns/1ps
module test_wave_block_gen;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr_en = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wr_data = '0;
    logic              mem_wr_en = 1'b0;
    logic [ADDR_W-1:0] mem_wr_addr = '0;
    logic [DATA_W-1:0] mem_wr_data = '0;
    logic              pps = 1'b0;
    logic              out_valid, out_sop, out_eop, out_sync;
    logic [63:0]       out_bsn;
    logic [DATA_W-1:0] out_data;

    always #2.5 clk = ~clk;

    wave_block_gen i_wave_block_gen (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wr_data(reg_wr_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .pps(pps),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_sync(out_sync), .out_bsn(out_bsn), .out_data(out_data)
    );

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sop;
        logic              eop;
        logic              sync;
        logic              first;
        logic [63:0]       bsn;
    } exp_t;

    exp_t        exp_q[$];
    logic [DATA_W-1:0] bm [DEPTH];
    int          checks = 0;
    int          fails  = 0;
    int          sop_seen = 0;
    int          idle_cnt = 0;
    int          c_spp, c_bps, c_gap, c_lo, c_hi;
    logic [63:0] c_bsn;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic reg_write(input int ofs, input logic [31:0] val);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_addr    = 3'(ofs);
        reg_wr_data = val;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic mem_write(input int a, input logic [DATA_W-1:0] val);
        @(negedge clk);
        mem_wr_en   = 1'b1;
        mem_wr_addr = ADDR_W'(a);
        mem_wr_data = val;
        bm[a]       = val;
        @(negedge clk);
        mem_wr_en   = 1'b0;
    endtask

    task automatic configure(input int spp, input int bps, input int gap,
                             input int lo, input int hi, input logic [63:0] bsn);
        reg_write(1, 32'(spp));
        reg_write(2, 32'(bps));
        reg_write(3, 32'(gap));
        reg_write(4, 32'(lo));
        reg_write(5, 32'(hi));
        reg_write(6, bsn[31:0]);
        reg_write(7, bsn[63:32]);
        c_spp = spp; c_bps = bps; c_gap = gap; c_lo = lo; c_hi = hi; c_bsn = bsn;
    endtask

    // Driver side of the scoreboard: expected beats from the requirements
    task automatic push_blocks(input int n);
        int eff_spp;
        int eff_bps;
        eff_spp = (c_spp == 0) ? 1 : c_spp;   // R4 zero acts as one
        eff_bps = (c_bps == 0) ? 1 : c_bps;   // R8 zero acts as one
        for (int b = 0; b < n; b++) begin
            int a;
            a = c_lo;
            for (int s = 0; s < eff_spp; s++) begin
                exp_t e;
                e.data  = bm[a];
                e.sop   = (s == 0);
                e.eop   = (s == eff_spp - 1);
                e.sync  = (s == 0) && ((b % eff_bps) == 0);
                e.first = (s == 0) && (b == 0);
                e.bsn   = c_bsn + 64'(b);
                exp_q.push_back(e);
                a = (a == c_hi) ? c_lo : a + 1;
            end
        end
    endtask

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected beat", 64'(out_data), 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_data == e.data, "R5/R10 data", 64'(out_data), 64'(e.data));
                    check({out_sop, out_eop} == {e.sop, e.eop}, "R4 framing",
                          64'({out_sop, out_eop}), 64'({e.sop, e.eop}));
                    check(out_sync == e.sync, "R8 sync", 64'(out_sync), 64'(e.sync));
                    check(out_bsn == e.bsn, "R7 bsn", out_bsn, e.bsn);
                    if (out_sop && !e.first)
                        check(idle_cnt == c_gap, "R6 gap", 64'(idle_cnt), 64'(c_gap));
                    if (!out_sop && idle_cnt != 0)
                        check(1'b0, "R4 hole in block", 64'(idle_cnt), 64'h0);
                end
                if (out_sop) sop_seen++;
                idle_cnt = 0;
            end else begin
                idle_cnt++;
            end
        end
    end

    task automatic run(input int n, input bit armed);
        int base;
        bit quiet;
        base = sop_seen;
        push_blocks(n);
        if (!armed) begin
            reg_write(0, 32'd1);
            check(!out_valid, "R2 latency edge0", 64'(out_valid), 64'h0);
            @(negedge clk);
            check(!out_valid, "R2 latency edge1", 64'(out_valid), 64'h0);
            @(negedge clk);
            check(out_sop && out_valid, "R2 latency edge2", 64'(out_sop), 64'h1);
        end else begin
            reg_write(0, 32'd2);
            quiet = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (out_valid) quiet = 1'b0;
            end
            check(quiet, "R3 waits for pps", 64'(!quiet), 64'h0);
            @(negedge clk);
            pps = 1'b1;
            @(negedge clk);
            pps = 1'b0;
            check(!out_valid, "R3 latency edge0", 64'(out_valid), 64'h0);
            @(negedge clk);
            check(out_sop && out_valid, "R3 latency edge1", 64'(out_sop), 64'h1);
        end
        wait (sop_seen >= base + n);
        reg_write(0, 32'd0);
        repeat (400) @(negedge clk);
        check(exp_q.size() == 0, "R9 block completed, no extra", 64'(exp_q.size()), 64'h0);
        exp_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!out_valid && !out_sop && !out_eop && !out_sync, "R1 reset outputs",
              64'({out_valid, out_sop, out_eop, out_sync}), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R1 idle after reset", 64'(out_valid), 64'h0);
        for (int i = 0; i < DEPTH; i++)
            mem_write(i, 32'hA500_0000 ^ (32'(i) * 32'h0001_0103));

        // R1 defaults: 256 samples, gap 80, sync period 781250, full memory, bsn 0
        c_spp = 256; c_bps = 781250; c_gap = 80; c_lo = 0; c_hi = DEPTH - 1; c_bsn = 64'h0;
        run(2, 1'b0);

        // R5/R7/R8: wrap inside a block, bsn carry into high word, sync every 3rd block
        configure(5, 3, 3, 10, 12, 64'h0000_0001_FFFF_FFFE);
        run(7, 1'b0);

        // R6: zero gap back to back; R7 bsn wraps at 2^64; R8 zero period
        configure(6, 0, 0, 5, 9, 64'hFFFF_FFFF_FFFF_FFFF);
        run(3, 1'b0);

        // R3: armed start on pps
        configure(8, 2, 4, 0, 3, 64'd100);
        run(3, 1'b1);

        // R4 zero length acts as one; R9 stop during a gap
        configure(0, 2, 20, 7, 7, 64'd5);
        run(3, 1'b0);

        // R10: rewritten words appear in later blocks
        mem_write(40, 32'hDEAD_0040);
        mem_write(41, 32'hBEEF_0041);
        configure(3, 1, 10, 40, 41, 64'd9);
        run(2, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R9: run did not finish, actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule